// File: doc/BRIEF.md
# Bypassing Fixed-Width Truncated Multiplier

This block multiplies two n-bit operands and returns an n-bit result: the upper half of the double-width product. It is meant to serve as the coefficient multiplier of a pipelined FFT stage. The low half of the partial-product matrix is never built. One estimated carry stands in for everything that half would have pushed upward. That carry is the OR of the partial-product bits in the highest discarded column, and it is added at the lowest retained weight.

The retained part of the matrix is summed by a chain of row adders. Two kinds of bypass cut switching activity:

- **Row bypass.** A row whose multiplier bit is zero has its adder inputs held at zero, and the incoming sum is routed around the row.
- **Column bypass.** A cell whose multiplicand bit is zero drops its partial-product input and only propagates the incoming sum and carry.

A parameter selects the arithmetic:

- **Unsigned** operands.
- **Two's-complement** operands. These use a sign-corrected matrix: cross terms with exactly one sign bit are inverted, and constants are added. In the signed case the constant and sign-fill bits that do not depend on a full row are gathered into one bias word, which seeds the row chain.

A second parameter adds an output register. The register has a valid strobe and adds exactly one cycle of latency.

Top module: `tbm_mult`

## Requirements
- R1: With ARITH=ARITH_UNSIGNED, the partial-product bit for operand bits a[i] and b[j] is a[i]&b[j], at weight i+j. y equals bits [2n-1:n] of the sum of two terms: every such bit with weight of at least n, and the compensation bit (R5) at weight n.
- R2: With ARITH=ARITH_TWOS, the bit at (i,j) is inverted when exactly one of i and j equals n-1. The constants 2^n and 2^(2n-1) are added. y is then formed as in R1 from these bits.
- R3: Row bypass applies when b[j]=0, for rows j=1..n-1 in unsigned mode and j=1..n-2 in signed mode. In that case row j passes its incoming sum through unchanged, and its adder inputs are held at zero. In unsigned mode, b=0 gives y=0.
- R4: Column bypass: a cell whose multiplicand bit is zero receives a zero partial-product bit and acts as a half adder on sum and carry. In unsigned mode, a=0 gives y=0.
- R5: The compensation bit is the OR of the n matrix bits of column n-1 (the pairs i+j=n-1, with the R2 inversions in signed mode). In unsigned mode, a=2^(n-1) with b=1 gives y=1.
- R6: Let the exact top half be bits [2n-1:n] of the true product. exact_top - y, read as an n-bit two's-complement number, lies in [-1, n-1] in both modes.
- R7: With OUT_REG=1, out_valid goes high on the clock edge after an edge that samples in_valid=1, and low after one that samples in_valid=0. y loads only when in_valid is sampled high and otherwise holds its value.
- R8: While rst_n is low, out_valid=0 and y=0. Reset is applied at once and released in step with clk after two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| a | input | WIDTH | Multiplicand |
| b | input | WIDTH | Multiplier |
| out_valid | output | 1 | y holds a new result |
| y | output | WIDTH | Upper half of the product with carry compensation |

## Verification
Row bypass and column bypass are active together in the same evaluation whenever both operands carry zero bits. At that moment the compensation column may also be non-zero. Random operands masked with random sparse patterns provoke this overlap, alongside directed cases: all-zero operands, single set bits, and full-scale and sign-extreme operands. Each result is judged against a bench model that sums the defined matrix bit by bit, and also against the error bound around the exact product, for both arithmetic variants side by side.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  typedef enum logic {
    ARITH_UNSIGNED = 1'b0,
    ARITH_TWOS     = 1'b1
  } arith_e;
endpackage

// File: rtl/tbm_cell.sv
module tbm_cell (
  input  logic x,
  input  logic p,
  input  logic ce,
  input  logic cin,
  output logic s,
  output logic co
);
  // ce low: multiplicand bit is zero, partial-product input is skipped (R4)
  always_comb begin
    if (ce) begin
      s  = x ^ p ^ cin;
      co = (x & p) | (x & cin) | (p & cin);
    end else begin
      s  = x ^ cin;
      co = x & cin;
    end
  end
endmodule

// File: rtl/tbm_ppgen.sv
module tbm_ppgen
  import tbm_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter arith_e      ARITH = ARITH_UNSIGNED
) (
  input  logic [W-1:0]         a,
  input  logic [W-1:0]         b,
  output logic [W-1:1]         row_en,
  output logic [W-1:1][W-1:0]  row_vec,
  output logic [W-1:1][W-1:0]  col_en,
  output logic [W-1:0]         col_bits,
  output logic [W-1:0]         bias
);
  localparam bit SGN = (ARITH == ARITH_TWOS);

  logic [W-1:0] a_eff;

  generate
    if (SGN) begin : g_aeff_s
      assign a_eff = {~a[W-1], a[W-2:0]};
    end else begin : g_aeff_u
      assign a_eff = a;
    end

    for (genvar j = 1; j < W; j++) begin : g_row
      if (SGN && (j == W-1)) begin : g_sign_row
        // sign row: never bypassed, inverted cross terms (R2)
        assign row_en[j]  = 1'b1;
        assign row_vec[j] = b[W-1] ? {a[W-1], ~a[W-2:0]} : {1'b0, {(W-1){1'b1}}};
        assign col_en[j]  = '1;
      end else begin : g_plain_row
        assign row_en[j]  = b[j];
        assign row_vec[j] = b[j] ? a_eff : '0;
        assign col_en[j]  = a_eff;
      end
    end

    for (genvar j = 0; j < W; j++) begin : g_col
      localparam int I   = W - 1 - j;
      localparam bit INV = SGN && ((I == W-1) != (j == W-1));
      if (INV) begin : g_inv
        assign col_bits[j] = ~(a[I] & b[j]);
      end else begin : g_pos
        assign col_bits[j] = a[I] & b[j];
      end
    end

    if (SGN) begin : g_bias_s
      // sign bits of bypassed rows, plus constants at weights n and 2n-1
      assign bias = {1'b1, 1'b0, ~b[W-2:1]} + W'(1);
    end else begin : g_bias_u
      assign bias = '0;
    end
  endgenerate
endmodule

// File: rtl/tbm_comp.sv
module tbm_comp #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] col_bits,
  input  logic [W-1:0] bias,
  output logic         cbit,
  output logic [W-1:0] acc0
);
  // AND terms arrive in col_bits; OR network estimates carry (R5)
  assign cbit = |col_bits;
  assign acc0 = bias + W'(cbit);
endmodule

// File: rtl/tbm_row.sv
module tbm_row #(
  parameter int unsigned W = 16,
  parameter int unsigned J = 1
) (
  input  logic [W-1:0] acc_in,
  input  logic [J-1:0] vec,
  input  logic [J-1:0] col_en,
  input  logic         row_en,
  output logic [W-1:0] acc_out
);
  logic [W-1:0] x_g;
  logic [W-2:0] p_g;
  logic [W-2:0] ce_g;
  logic [W-1:0] cy;
  logic [W-1:0] sum;

  // operand isolation: a bypassed row sees constant zero inputs (R3)
  assign x_g   = row_en ? acc_in : '0;
  assign cy[0] = 1'b0;

  generate
    for (genvar k = 0; k < W-1; k++) begin : g_bit
      if (k < J) begin : g_pp
        assign p_g[k]  = row_en & vec[k];
        assign ce_g[k] = row_en & col_en[k];
      end else begin : g_nopp
        assign p_g[k]  = 1'b0;
        assign ce_g[k] = 1'b0;
      end
      tbm_cell u_cell (
        .x   (x_g[k]),
        .p   (p_g[k]),
        .ce  (ce_g[k]),
        .cin (cy[k]),
        .s   (sum[k]),
        .co  (cy[k+1])
      );
    end
  endgenerate

  assign sum[W-1] = x_g[W-1] ^ cy[W-1];
  assign acc_out  = row_en ? sum : acc_in;
endmodule

// File: rtl/tbm_mult.sv
module tbm_mult
  import tbm_pkg::*;
#(
  parameter int unsigned WIDTH   = 16,
  parameter arith_e      ARITH   = ARITH_UNSIGNED,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             out_valid,
  output logic [WIDTH-1:0] y
);
  localparam int unsigned W   = WIDTH;
  localparam bit          UNS = (ARITH == ARITH_UNSIGNED);

  logic [W-1:1]        row_en;
  logic [W-1:1][W-1:0] row_vec;
  logic [W-1:1][W-1:0] col_en;
  logic [W-1:0]        col_bits;
  logic [W-1:0]        bias;
  logic                cbit;
  logic [W-1:0]        acc [W];
  logic [W-1:0]        prod;

  // reset: asserted asynchronously, released on clk (R8)
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tbm_ppgen #(.W(W), .ARITH(ARITH)) u_ppgen (
    .a        (a),
    .b        (b),
    .row_en   (row_en),
    .row_vec  (row_vec),
    .col_en   (col_en),
    .col_bits (col_bits),
    .bias     (bias)
  );

  tbm_comp #(.W(W)) u_comp (
    .col_bits (col_bits),
    .bias     (bias),
    .cbit     (cbit),
    .acc0     (acc[0])
  );

  generate
    for (genvar j = 1; j < W; j++) begin : g_rows
      tbm_row #(.W(W), .J(j)) u_row (
        .acc_in  (acc[j-1]),
        .vec     (row_vec[j][W-1:W-j]),
        .col_en  (col_en[j][W-1:W-j]),
        .row_en  (row_en[j]),
        .acc_out (acc[j])
      );

      // R4: a skipped column never carries a live partial-product bit
      a_r4_col_skip_zero : assert property (@(posedge clk) disable iff (!rst_sync_n)
        ((~col_en[j]) & row_vec[j]) == '0);
    end
  endgenerate

  assign prod = acc[W-1];

  // R5: unsigned zero operand leaves the compensation column empty
  a_r5_comp_quiet : assert property (@(posedge clk) disable iff (!rst_sync_n)
    (UNS && (a == '0 || b == '0)) |-> !cbit);

  generate
    if (OUT_REG) begin : g_oreg
      logic             vld_q, vld_d;
      logic [W-1:0]     y_q, y_d;

      always_comb begin
        vld_d = in_valid;
        y_d   = y_q;
        if (in_valid) y_d = prod;
      end

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
          vld_q <= 1'b0;
          y_q   <= '0;
        end else begin
          vld_q <= vld_d;
          y_q   <= y_d;
        end
      end

      assign out_valid = vld_q;
      assign y         = y_q;

      // R7: one-cycle latency and hold
      a_r7_valid_follow : assert property (@(posedge clk) disable iff (!rst_sync_n)
        in_valid |=> out_valid);
      a_r7_valid_idle : assert property (@(posedge clk) disable iff (!rst_sync_n)
        !in_valid |=> !out_valid);
      a_r7_hold : assert property (@(posedge clk) disable iff (!rst_sync_n)
        !in_valid |=> $stable(y));
      // R3: all rows bypassed in unsigned mode gives zero
      a_r3_all_rows_skipped : assert property (@(posedge clk) disable iff (!rst_sync_n)
        (UNS && in_valid && b == '0) |=> (y == '0));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign y         = prod;
    end
  endgenerate
endmodule

// File: tb/tbm_mult_tb.sv
`timescale 1ns/1ps
module tbm_mult_tb;
  import tbm_pkg::*;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [N-1:0] a, b;
  logic         v_u, v_s;
  logic [N-1:0] y_u, y_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  tbm_mult #(.WIDTH(N), .ARITH(ARITH_UNSIGNED), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v_u), .y(y_u));

  tbm_mult #(.WIDTH(N), .ARITH(ARITH_TWOS), .OUT_REG(1'b1)) u_dut_sgn (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b),
    .out_valid(v_s), .y(y_s));

  function automatic logic [N-1:0] gold(input logic [N-1:0] x, input logic [N-1:0] z, input bit sg);
    logic [2*N-1:0] k;
    bit c;
    k = '0;
    c = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        bit p;
        p = x[i] & z[j];
        if (sg && ((i == N-1) != (j == N-1))) p = !p;
        if (i + j >= N) k = k + ((2*N)'(p) << (i + j));
        else if (i + j == N-1) c = c | p;
      end
    end
    if (sg) k = k + ((2*N)'(1) << N) + ((2*N)'(1) << (2*N-1));
    k = k + ((2*N)'(c) << N);
    return k[2*N-1:N];
  endfunction

  function automatic logic [N-1:0] exact_top(input logic [N-1:0] x, input logic [N-1:0] z, input bit sg);
    logic [2*N-1:0] f;
    longint sx, sz;
    if (sg) begin
      sx = longint'($signed(x));
      sz = longint'($signed(z));
    end else begin
      sx = longint'({1'b0, x});
      sz = longint'({1'b0, z});
    end
    f = (2*N)'(sx * sz);
    return f[2*N-1:N];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_bound(input string req, input logic [N-1:0] got, input logic [N-1:0] ex);
    logic signed [N-1:0] d;
    d = ex - got;
    chk((d >= -1) && (d <= N-1), req, got, ex);
  endtask

  logic [N-1:0] pa, pb, last_u, last_s;
  bit pend = 0;

  task automatic verify();
    chk(v_u === 1'b1 && v_s === 1'b1, "R7 out_valid", {15'd0, v_u}, 16'd1);
    chk(y_u === gold(pa, pb, 0), "R1 unsigned", y_u, gold(pa, pb, 0));
    chk(y_s === gold(pa, pb, 1), "R2 signed", y_s, gold(pa, pb, 1));
    chk_bound("R6 unsigned bound", y_u, exact_top(pa, pb, 0));
    chk_bound("R6 signed bound", y_s, exact_top(pa, pb, 1));
    last_u = y_u;
    last_s = y_s;
  endtask

  task automatic apply(input logic [N-1:0] x, input logic [N-1:0] z);
    @(negedge clk);
    if (pend) verify();
    a = x; b = z; in_valid = 1'b1;
    pa = x; pb = z; pend = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) verify();
    in_valid = 1'b0;
    pend = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; in_valid = 1'b0; a = '0; b = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(v_u === 1'b0 && v_s === 1'b0, "R8 reset valid", {15'd0, v_u}, 16'd0);
    chk(y_u === '0 && y_s === '0, "R8 reset data", y_u, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(v_u === 1'b0, "R8 idle after release", {15'd0, v_u}, 16'd0);

    // R3: multiplier zero bypasses every row
    apply(16'hBEEF, 16'h0000);
    flush();
    chk(y_u === '0, "R3 b zero", y_u, 16'd0);
    // R4: multiplicand zero bypasses every column
    apply(16'h0000, 16'h7A5C);
    flush();
    chk(y_u === '0, "R4 a zero", y_u, 16'd0);
    // R5: only the compensation column is populated
    apply(16'h8000, 16'h0001);
    flush();
    chk(y_u === 16'h0001, "R5 comp carry", y_u, 16'h0001);

    // corners
    apply(16'hFFFF, 16'hFFFF);
    apply(16'h8000, 16'h8000);
    apply(16'h7FFF, 16'h8000);
    apply(16'h7FFF, 16'h7FFF);
    apply(16'h0001, 16'h0001);
    apply(16'hFFFF, 16'h0001);
    apply(16'h5555, 16'hAAAA);
    flush();

    // R7: hold when in_valid low
    a = 16'h1234; b = 16'h4321;
    repeat (2) @(negedge clk);
    chk(v_u === 1'b0, "R7 valid drops", {15'd0, v_u}, 16'd0);
    chk(y_u === last_u && y_s === last_s, "R7 data held", y_u, last_u);

    // random dense, and sparse masks so row and column bypass overlap
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] x, z;
      x = N'($urandom);
      z = N'($urandom);
      if (n % 3 == 1) begin
        x = x & N'($urandom) & N'($urandom);
        z = z & N'($urandom) & N'($urandom);
      end
      apply(x, z);
      if (n % 97 == 0) flush();
    end
    flush();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule